// File: doc/BRIEF.md
# Two-Field Bitmap Intersection Classifier

This block sorts packets into rules by looking at two header fields. Each field's value range is cut into sorted elementary intervals. Every interval holds a precomputed bit vector with one bit per rule, and a bit is set when that rule accepts any value in the interval. For each packet the block finds the interval of each field and ANDs the two vectors. The set bits that remain are the rules that match on both fields. The rule with the lowest index wins, because a lower index means a higher priority. The block then reports that rule and its action.

Software loads the boundaries, the per-interval vectors and the per-rule actions through one write port. The intervals are computed offline and are outside this block. Lookups run through a three-stage pipeline and can arrive on every cycle. The block is sized for small rule sets, tens to a few hundred rules, because the vector width grows with the rule count.

Top module: `bmi_classifier`

## Requirements
- R1: While reset is held and in the cycle after it, out_done and out_hit are 0, out_rule is 0 and out_act equals DEFAULT_ACT.
- R2: The interval index of a field is the number of loaded boundaries of that field that are less than or equal to the field value. A value equal to a boundary therefore falls in the upper interval. in_key_a uses dimension 0 and in_key_b uses dimension 1.
- R3: A rule matches only if its bit is set both in the dimension 0 vector of the key A interval and in the dimension 1 vector of the key B interval.
- R4: When several rules match, out_rule is the lowest matching index. The bench covers the case where only rule NUM_RULES-1 matches.
- R5: On a hit, out_act is the action loaded for the reported rule.
- R6: When no rule matches, out_done is 1, out_hit is 0, out_rule is 0 and out_act equals DEFAULT_ACT.
- R7: A lookup sampled with in_valid at clock edge k produces out_done=1 after edge k+2. One lookup can be accepted on every cycle, and out_done is 1 only for such results.
- R8: A write with ld_en=1 takes effect from the next edge, and its meaning is chosen by ld_kind. Code 0 writes boundary ld_addr of dimension ld_dim from ld_value. Code 1 writes the rule vector of interval ld_addr of dimension ld_dim from ld_map. Code 2 writes the action of rule ld_addr from the low ACT_W bits of ld_value. Code 3 changes nothing.
- R9: While out_done is 0, out_hit is 0, out_rule is 0 and out_act equals DEFAULT_ACT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Lookup request strobe |
| in_key_a | input | FIELD_W | First header field (dimension 0) |
| in_key_b | input | FIELD_W | Second header field (dimension 1) |
| ld_en | input | 1 | Table write strobe |
| ld_kind | input | 2 | Write kind: 0 boundary, 1 rule vector, 2 action, 3 none |
| ld_dim | input | 1 | Dimension for boundary and vector writes |
| ld_addr | input | ADDR_W | Boundary number, interval number or rule number |
| ld_value | input | VAL_W | Boundary value or action |
| ld_map | input | NUM_RULES | Rule vector for an interval |
| out_done | output | 1 | Result valid |
| out_hit | output | 1 | At least one rule matched |
| out_rule | output | RULE_W | Index of the winning rule |
| out_act | output | ACT_W | Action of the winning rule, or the default action |

## Verification
The bench builds the block with 32 rules, 6 intervals per field, 12-bit fields and a default action of 0xEE. With 12-bit fields, random keys land on both sides of every boundary and sometimes exactly on one. With 6 intervals, a one-hot vector per interval makes the reported rule equal the interval index, so the interval search can be read straight from the outputs. The 32-bit rule vectors keep the top rule in reach, as well as overlapping, disjoint and empty intersections, alongside random vectors of about one bit in four.

// File: rtl/bmi_pkg.sv
package bmi_pkg;

    typedef enum logic [1:0] {
        LD_BOUND = 2'd0,
        LD_MAP   = 2'd1,
        LD_ACT   = 2'd2,
        LD_NONE  = 2'd3
    } ld_kind_e;

    localparam int NUM_DIMS = 2;

endpackage

// File: rtl/bmi_interval_search.sv
module bmi_interval_search #(
    parameter int W     = 16,
    parameter int NB    = 15,
    parameter int IDX_W = 4
) (
    input  logic [W-1:0]         key,
    input  logic [NB-1:0][W-1:0] bounds,
    output logic [IDX_W-1:0]     idx
);

    logic [NB-1:0] ge;

    for (genvar j = 0; j < NB; j++) begin : g_cmp
        assign ge[j] = (key >= bounds[j]);
    end

    always_comb begin
        idx = '0;
        for (int j = 0; j < NB; j++) begin
            idx = idx + IDX_W'(ge[j]);
        end
    end

endmodule

// File: rtl/bmi_priority_pick.sv
module bmi_priority_pick #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bmi_classifier.sv
module bmi_classifier
    import bmi_pkg::*;
#(
    parameter int FIELD_W       = 16,
    parameter int NUM_RULES     = 64,
    parameter int NUM_INTERVALS = 16,
    parameter int ACT_W         = 8,
    parameter logic [ACT_W-1:0] DEFAULT_ACT = '0,
    localparam int RULE_W = $clog2(NUM_RULES),
    localparam int ADDR_W = $clog2(NUM_RULES > NUM_INTERVALS ? NUM_RULES : NUM_INTERVALS),
    localparam int VAL_W  = (FIELD_W > ACT_W) ? FIELD_W : ACT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [FIELD_W-1:0]   in_key_a,
    input  logic [FIELD_W-1:0]   in_key_b,
    input  logic                 ld_en,
    input  logic [1:0]           ld_kind,
    input  logic                 ld_dim,
    input  logic [ADDR_W-1:0]    ld_addr,
    input  logic [VAL_W-1:0]     ld_value,
    input  logic [NUM_RULES-1:0] ld_map,
    output logic                 out_done,
    output logic                 out_hit,
    output logic [RULE_W-1:0]    out_rule,
    output logic [ACT_W-1:0]     out_act
);

    localparam int NB    = NUM_INTERVALS - 1;
    localparam int IDX_W = $clog2(NUM_INTERVALS);

    typedef struct packed {
        logic [NUM_DIMS-1:0][NB-1:0][FIELD_W-1:0]              bnd;
        logic [NUM_DIMS-1:0][NUM_INTERVALS-1:0][NUM_RULES-1:0] map;
        logic [NUM_RULES-1:0][ACT_W-1:0]                       tbl_act;
        logic                                                  s1_v;
        logic [NUM_DIMS-1:0][IDX_W-1:0]                        s1_idx;
        logic                                                  s2_v;
        logic [NUM_RULES-1:0]                                  s2_and;
        logic                                                  o_done;
        logic                                                  o_hit;
        logic [RULE_W-1:0]                                     o_rule;
        logic [ACT_W-1:0]                                      o_act;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_DIMS-1:0][FIELD_W-1:0] keys;
    logic [NUM_DIMS-1:0][IDX_W-1:0]   idx_w;
    logic                             pick_found;
    logic [RULE_W-1:0]                pick_idx;
    logic [NUM_RULES-1:0]             and_vec_q;

    assign keys[0] = in_key_a;
    assign keys[1] = in_key_b;

    for (genvar g = 0; g < NUM_DIMS; g++) begin : g_dim
        bmi_interval_search #(
            .W     (FIELD_W),
            .NB    (NB),
            .IDX_W (IDX_W)
        ) i_search (
            .key    (keys[g]),
            .bounds (st_q.bnd[g]),
            .idx    (idx_w[g])
        );
    end

    bmi_priority_pick #(
        .N     (NUM_RULES),
        .IDX_W (RULE_W)
    ) i_pick (
        .vec   (st_q.s2_and),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d = st_q;

        // table writes
        if (ld_en) begin
            unique case (ld_kind_e'(ld_kind))
                LD_BOUND: begin
                    if (int'(ld_addr) < NB) begin
                        st_d.bnd[ld_dim][ld_addr[IDX_W-1:0]] = ld_value[FIELD_W-1:0];
                    end
                end
                LD_MAP: begin
                    if (int'(ld_addr) < NUM_INTERVALS) begin
                        st_d.map[ld_dim][ld_addr[IDX_W-1:0]] = ld_map;
                    end
                end
                LD_ACT: begin
                    if (int'(ld_addr) < NUM_RULES) begin
                        st_d.tbl_act[ld_addr[RULE_W-1:0]] = ld_value[ACT_W-1:0];
                    end
                end
                default: begin
                end
            endcase
        end

        // stage 1: interval indices
        st_d.s1_v   = in_valid;
        st_d.s1_idx = idx_w;

        // stage 2: bitmap intersection
        st_d.s2_v   = st_q.s1_v;
        st_d.s2_and = st_q.map[0][st_q.s1_idx[0]] & st_q.map[1][st_q.s1_idx[1]];

        // stage 3: priority pick and action
        st_d.o_done = st_q.s2_v;
        st_d.o_hit  = st_q.s2_v & pick_found;
        st_d.o_rule = (st_q.s2_v & pick_found) ? pick_idx : '0;
        st_d.o_act  = (st_q.s2_v & pick_found) ? st_q.tbl_act[pick_idx] : DEFAULT_ACT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.o_act <= DEFAULT_ACT;
        end else begin
            st_q <= st_d;
        end
    end

    assign and_vec_q = st_q.s2_and;
    assign out_done  = st_q.o_done;
    assign out_hit   = st_q.o_hit;
    assign out_rule  = st_q.o_rule;
    assign out_act   = st_q.o_act;

endmodule

// File: rtl/bmi_checker.sv
module bmi_checker #(
    parameter int NUM_RULES = 64,
    parameter int ACT_W     = 8,
    parameter int RULE_W    = 6,
    parameter logic [ACT_W-1:0] DEFAULT_ACT = '0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_done,
    input logic                 out_hit,
    input logic [RULE_W-1:0]    rule,
    input logic [ACT_W-1:0]     act,
    input logic [NUM_RULES-1:0] and_vec
);

    logic [2:0]           vpipe;
    logic [NUM_RULES-1:0] and_prev;
    logic [NUM_RULES-1:0] low_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe    <= '0;
            and_prev <= '0;
        end else begin
            vpipe    <= {vpipe[1:0], in_valid};
            and_prev <= and_vec;
        end
    end

    assign low_mask = (NUM_RULES'(1) << rule) - NUM_RULES'(1);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_done && !out_hit && rule == '0 && act == DEFAULT_ACT));

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_done == vpipe[2]);

    assert_hit_iff_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_hit == (|and_prev)));

    assert_first_set_R4: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (and_prev[rule] && ((and_prev & low_mask) == '0)));

    assert_miss_default_R6: assert property (@(posedge clk) disable iff (rst)
        (out_done && !out_hit) |-> (rule == '0 && act == DEFAULT_ACT));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> (!out_hit && rule == '0 && act == DEFAULT_ACT));

endmodule

bind bmi_classifier bmi_checker #(
    .NUM_RULES   (NUM_RULES),
    .ACT_W       (ACT_W),
    .RULE_W      (RULE_W),
    .DEFAULT_ACT (DEFAULT_ACT)
) i_bmi_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_done (out_done),
    .out_hit  (out_hit),
    .rule     (out_rule),
    .act      (out_act),
    .and_vec  (and_vec_q)
);

// File: tb/test_bmi_classifier.sv
module test_bmi_classifier;

    localparam int FW  = 12;
    localparam int NR  = 32;
    localparam int NI  = 6;
    localparam int NBB = NI - 1;
    localparam int AW  = 8;
    localparam logic [AW-1:0] DEF = 8'hEE;
    localparam int RW  = $clog2(NR);
    localparam int ADW = $clog2(NR > NI ? NR : NI);
    localparam int VW  = (FW > AW) ? FW : AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [FW-1:0] in_key_a, in_key_b;
    logic          ld_en;
    logic [1:0]    ld_kind;
    logic          ld_dim;
    logic [ADW-1:0] ld_addr;
    logic [VW-1:0] ld_value;
    logic [NR-1:0] ld_map;
    logic          out_done, out_hit;
    logic [RW-1:0] out_rule;
    logic [AW-1:0] out_act;

    always #5 clk = ~clk;

    bmi_classifier #(
        .FIELD_W       (FW),
        .NUM_RULES     (NR),
        .NUM_INTERVALS (NI),
        .ACT_W         (AW),
        .DEFAULT_ACT   (DEF)
    ) i_bmi_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_key_a(in_key_a), .in_key_b(in_key_b),
        .ld_en(ld_en), .ld_kind(ld_kind), .ld_dim(ld_dim),
        .ld_addr(ld_addr), .ld_value(ld_value), .ld_map(ld_map),
        .out_done(out_done), .out_hit(out_hit),
        .out_rule(out_rule), .out_act(out_act)
    );

    // reference tables
    int            m_bnd [2][NBB];
    logic [NR-1:0] m_map [2][NI];
    logic [AW-1:0] m_act [NR];

    // expected-result pipeline, slot 2 is due now
    bit    p_done [3];
    bit    p_hit  [3];
    int    p_rule [3];
    int    p_act  [3];
    string p_tag  [3];

    int n_checks = 0;
    int n_fail   = 0;

    function automatic int f_interval(int d, int key);
        int c = 0;
        for (int j = 0; j < NBB; j++) if (key >= m_bnd[d][j]) c++;
        return c;
    endfunction

    function automatic void f_expect(int a, int b, output bit h, output int r, output int ac);
        logic [NR-1:0] both;
        both = m_map[0][f_interval(0, a)] & m_map[1][f_interval(1, b)];
        h = 1'b0; r = 0; ac = int'(DEF);
        for (int i = NR - 1; i >= 0; i--) begin
            if (both[i]) begin h = 1'b1; r = i; ac = int'(m_act[i]); end
        end
    endfunction

    task automatic chk(string tag, string field, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, field, got, exp);
        end
    endtask

    task automatic check_out();
        chk("R7", "done", int'(out_done), int'(p_done[2]));
        chk(p_tag[2], "hit", int'(out_hit), int'(p_hit[2]));
        chk(p_tag[2], "rule", int'(out_rule), p_rule[2]);
        chk(p_hit[2] ? "R5" : p_tag[2], "act", int'(out_act), p_act[2]);
    endtask

    task automatic tick(bit v, int a, int b, string tag,
                        bit le, int kind, int dim, int addr, int val, logic [NR-1:0] mp);
        bit h; int r; int ac;
        @(negedge clk);
        check_out();
        for (int s = 2; s > 0; s--) begin
            p_done[s] = p_done[s-1]; p_hit[s] = p_hit[s-1];
            p_rule[s] = p_rule[s-1]; p_act[s] = p_act[s-1]; p_tag[s] = p_tag[s-1];
        end
        if (v) begin
            f_expect(a, b, h, r, ac);
            p_done[0] = 1'b1; p_hit[0] = h; p_rule[0] = r; p_act[0] = ac; p_tag[0] = tag;
        end else begin
            p_done[0] = 1'b0; p_hit[0] = 1'b0; p_rule[0] = 0; p_act[0] = int'(DEF); p_tag[0] = "R9";
        end
        in_valid = v;
        in_key_a = FW'(a);
        in_key_b = FW'(b);
        ld_en    = le;
        ld_kind  = 2'(kind);
        ld_dim   = 1'(dim);
        ld_addr  = ADW'(addr);
        ld_value = VW'(val);
        ld_map   = mp;
    endtask

    task automatic look(int a, int b, string tag);
        tick(1'b1, a, b, tag, 1'b0, 0, 0, 0, 0, '0);
    endtask

    task automatic idle();
        tick(1'b0, 0, 0, "R9", 1'b0, 0, 0, 0, 0, '0);
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) idle();
    endtask

    task automatic load_bnd(int d, int j, int val);
        m_bnd[d][j] = val;
        tick(1'b0, 0, 0, "R9", 1'b1, 0, d, j, val, '0);
    endtask

    task automatic load_map(int d, int k, logic [NR-1:0] mp);
        m_map[d][k] = mp;
        tick(1'b0, 0, 0, "R9", 1'b1, 1, d, k, 0, mp);
    endtask

    task automatic load_act(int r, int val);
        m_act[r] = AW'(val);
        tick(1'b0, 0, 0, "R9", 1'b1, 2, 0, r, val, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog got=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < 3; s++) begin
            p_done[s] = 1'b0; p_hit[s] = 1'b0; p_rule[s] = 0; p_act[s] = int'(DEF); p_tag[s] = "R9";
        end
        for (int d = 0; d < 2; d++) begin
            for (int j = 0; j < NBB; j++) m_bnd[d][j] = 0;
            for (int k = 0; k < NI; k++) m_map[d][k] = '0;
        end
        for (int r = 0; r < NR; r++) m_act[r] = '0;

        rst = 1'b1; in_valid = 1'b0; in_key_a = '0; in_key_b = '0;
        ld_en = 1'b0; ld_kind = '0; ld_dim = 1'b0; ld_addr = '0; ld_value = '0; ld_map = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1", "done", int'(out_done), 0);
        chk("R1", "hit", int'(out_hit), 0);
        chk("R1", "rule", int'(out_rule), 0);
        chk("R1", "act", int'(out_act), int'(DEF));
        rst = 1'b0;

        // config A: one-hot per dimension 0 interval, so rule == interval index (R2)
        for (int j = 0; j < NBB; j++) load_bnd(0, j, 100 * (j + 1));
        for (int j = 0; j < NBB; j++) load_bnd(1, j, 1000 + 500 * j);
        for (int k = 0; k < NI; k++) load_map(0, k, NR'(1) << k);
        for (int k = 0; k < NI; k++) load_map(1, k, '1);
        for (int r = 0; r < NR; r++) load_act(r, r * 7 + 3);
        flush();
        look(0, 0, "R2");
        look(4095, 4095, "R2");
        for (int j = 0; j < NBB; j++) begin
            look(m_bnd[0][j] - 1, 77, "R2");
            look(m_bnd[0][j], 3000, "R2");
        end
        flush();
        // dimension 1 decides: swap roles
        for (int k = 0; k < NI; k++) load_map(0, k, '1);
        for (int k = 0; k < NI; k++) load_map(1, k, NR'(1) << (k + 10));
        for (int j = 0; j < NBB; j++) begin
            look(5, m_bnd[1][j] - 1, "R2");
            look(5, m_bnd[1][j], "R2");
        end
        flush();
        // R8: kind code 3 must leave every table unchanged
        tick(1'b0, 0, 0, "R9", 1'b1, 3, 1, 2, 0, '0);
        tick(1'b0, 0, 0, "R9", 1'b1, 3, 0, 0, 0, '0);
        look(150, 1700, "R8");
        look(50, 500, "R8");
        flush();

        // config B: directed intersections
        load_map(0, 0, (NR'(1) << 3) | (NR'(1) << 9));
        load_map(1, 0, (NR'(1) << 9) | (NR'(1) << 20));
        load_map(0, 1, (NR'(1) << 2) | (NR'(1) << 5) | (NR'(1) << (NR - 1)));
        load_map(1, 1, (NR'(1) << 2) | (NR'(1) << 5) | (NR'(1) << (NR - 1)));
        load_map(0, 2, NR'(1) << (NR - 1));
        load_map(1, 2, '1);
        load_map(0, 3, NR'(1) << 4);
        load_map(1, 3, NR'(1) << 5);
        flush();
        look(50, 500, "R3");    // rule 9 only common bit
        look(150, 1200, "R4");  // lowest of 2,5,31
        look(250, 1700, "R4");  // only top rule
        look(350, 2200, "R6");  // disjoint -> miss
        look(50, 2200, "R6");
        look(150, 500, "R3");
        flush();

        // random rounds, back-to-back and gapped
        for (int rnd = 0; rnd < 3; rnd++) begin
            int prev;
            prev = 0;
            for (int j = 0; j < NBB; j++) begin
                prev = prev + 1 + int'($urandom % 600);
                load_bnd(0, j, prev);
            end
            prev = 0;
            for (int j = 0; j < NBB; j++) begin
                prev = prev + 1 + int'($urandom % 600);
                load_bnd(1, j, prev);
            end
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < NI; k++)
                    load_map(d, k, NR'($urandom & $urandom));
            load_map(1, 0, '0);
            for (int r = 0; r < NR; r++) load_act(r, int'($urandom % 256));
            flush();
            for (int n = 0; n < 400; n++) begin
                int a, b;
                a = int'($urandom % 4096);
                b = int'($urandom % 4096);
                if ($urandom % 8 == 0) a = m_bnd[0][$urandom % NBB];
                if ($urandom % 8 == 0) b = m_bnd[1][$urandom % NBB];
                if ($urandom % 5 == 0) idle();
                else look(a, b, "R3");
            end
            flush();
        end

        flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule